// File: doc/BRIEF.md
# Prescaled Wake-Up System Timer

A free-running down-count timer meant for timekeeping and for waking a sleeping system. One of two count strobes is selected as the timer's input. The selected strobe drives a power-of-two prescaler, and each prescaler wrap steps a loadable down counter once. The total count is PRE_W + CNT_W bits, 7 + 16 = 23 by default. When the prescaler and the counter are both at zero on a counted strobe, the timer fires. It then sets a sticky event flag, and the prescaler and the counter restart from full scale and from the reload register on the same edge.

Software controls the timer through a few inputs:
- a run enable;
- a source select;
- a reload write port;
- an interrupt enable;
- a write-one-to-clear strobe for the flag.

The block also takes a power-down indication. It never stops counting while that input is high, and while it is high the wake-up output follows the flag whatever the interrupt enable says. The interrupt and wake-up outputs are registered together with the flag.

Top module: `wake_timer`

## Requirements
- R1: After a synchronous reset, `evt_flag`, `irq` and `wake` are 0, the prescaler holds its maximum value (all ones), and the counter and the reload register hold all ones.
- R2: While `run_en` is 1, each selected strobe decrements the prescaler. A strobe that finds the prescaler at 0 sets it back to all ones and decrements the counter. The timer therefore fires once every (reload+1)*2^PRE_W counted strobes.
- R3: A counted strobe that finds both the prescaler and the counter at 0 is a timer event. On the same edge `evt_flag` becomes 1, the prescaler goes to all ones and the counter takes the value of the reload register.
- R4: While `run_en` is 0, strobes are ignored and the count holds, so no event occurs.
- R5: A reload write (`reload_we`=1) always updates the reload register. While `run_en` is 0, the same write also loads the counter and sets the prescaler to all ones, and the timer starts counting from there once it is enabled. While `run_en` is 1, the write leaves the running count alone, and the new value takes effect at the next event.
- R6: With `src_sel`=0 the timer counts `tick_a`; with `src_sel`=1 it counts `tick_b`. The strobe that is not selected has no effect.
- R7: `flag_clr`=1 clears `evt_flag` on the next edge. If an event happens in the same cycle, the event wins and the flag stays 1.
- R8: `irq` is 1 exactly when the flag value being registered is 1 and `irq_en` was 1 in the same cycle.
- R9: `wake` is 1 exactly when the flag value being registered is 1 and either `irq_en` or `power_down` was 1. `power_down` never stops or alters counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Count strobe, source 0 |
| tick_b | input | 1 | Count strobe, source 1 |
| src_sel | input | 1 | Selects the counted strobe (0: tick_a, 1: tick_b) |
| run_en | input | 1 | Timer enable |
| reload_we | input | 1 | Reload register write strobe |
| reload_data | input | CNT_W | Reload value |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| power_down | input | 1 | System power-down indication |
| evt_flag | output | 1 | Sticky timer event flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench builds the timer with PRE_W=3 and CNT_W=6, so the prescaler wraps every 8 strobes and a reload of 0 to 3 gives periods of 8 to 32 cycles. At that scale, exact period measurement, reload writes during a run, and a flag clear landing on the very cycle of an event all fit into a few hundred cycles. The random phase then crosses many events with every mix of strobe source, enable, clear and power-down.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_PRE_W_DEF = 7;
  localparam int WT_CNT_W_DEF = 16;

  typedef struct packed {
    logic step;
    logic restart;
  } wt_pre_ctl_t;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wt_pkg::wt_pre_ctl_t   ctl,
  output logic                  wrap
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  assign wrap = ctl.step && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= PRE_MAX;
    end else if (ctl.restart) begin
      pre_q <= PRE_MAX;
    end else if (ctl.step) begin
      if (pre_q == '0) pre_q <= PRE_MAX;
      else             pre_q <= pre_q - 1'b1;
    end
  end
endmodule

// File: rtl/wt_down_counter.sv
module wt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             load_now,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_hit
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;

  assign cnt      = cnt_q;
  assign zero_hit = wrap && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
    end else begin
      if (wr_en) reload_q <= wr_data;
      if (load_now)      cnt_q <= wr_data;
      else if (zero_hit) cnt_q <= reload_q;
      else if (wrap)     cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wt_flag_ctrl.sv
module wt_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  input  logic irq_en,
  input  logic power_down,
  output logic flag,
  output logic irq,
  output logic wake
);
  logic flag_q, irq_q, wake_q;
  logic flag_n;

  always_comb begin
    if (evt)      flag_n = 1'b1;
    else if (clr) flag_n = 1'b0;
    else          flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n & irq_en;
      wake_q <= flag_n & (irq_en | power_down);
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
  assign wake = wake_q;
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int PRE_W = wt_pkg::WT_PRE_W_DEF,
  parameter int CNT_W = wt_pkg::WT_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             src_sel,
  input  logic             run_en,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_data,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             power_down,
  output logic             evt_flag,
  output logic             irq,
  output logic             wake
);
  logic                tick_sel;
  logic                pre_wrap;
  logic                zero_evt;
  logic                load_idle;
  logic [CNT_W-1:0]    cnt_val;
  wt_pkg::wt_pre_ctl_t pre_ctl;

  assign tick_sel        = src_sel ? tick_b : tick_a;
  assign load_idle       = reload_we && !run_en;
  assign pre_ctl.step    = run_en && tick_sel;
  assign pre_ctl.restart = load_idle;

  wt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .ctl  (pre_ctl),
    .wrap (pre_wrap)
  );

  wt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wrap     (pre_wrap),
    .load_now (load_idle),
    .wr_en    (reload_we),
    .wr_data  (reload_data),
    .cnt      (cnt_val),
    .zero_hit (zero_evt)
  );

  wt_flag_ctrl u_flag (
    .clk        (clk),
    .rst        (rst),
    .evt        (zero_evt),
    .clr        (flag_clr),
    .irq_en     (irq_en),
    .power_down (power_down),
    .flag       (evt_flag),
    .irq        (irq),
    .wake       (wake)
  );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             reload_we,
  input logic             flag_clr,
  input logic             power_down,
  input logic             evt_flag,
  input logic             irq,
  input logic             wake,
  input logic             evt,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt
);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    evt |=> evt_flag);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !evt) |=> !evt_flag);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> evt_flag);

  p_wake_in_pd_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && $past(power_down)) |-> wake);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wrap && cnt != '0 && !(reload_we && !run_en)) |=> (cnt == $past(cnt) - 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !reload_we) |=> $stable(cnt));
endmodule

bind wake_timer wake_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .reload_we  (reload_we),
  .flag_clr   (flag_clr),
  .power_down (power_down),
  .evt_flag   (evt_flag),
  .irq        (irq),
  .wake       (wake),
  .evt        (zero_evt),
  .wrap       (pre_wrap),
  .cnt        (cnt_val)
);

// File: tb/wake_timer_bench.sv
module wake_timer_bench;
  localparam int CLK_PER = 10;
  localparam int PRE_W   = 3;
  localparam int CNT_W   = 6;
  localparam logic [PRE_W-1:0] PMAX = {PRE_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_a = 1'b1, tick_b = 1'b0, src_sel = 1'b0, run_en = 1'b0;
  logic reload_we = 1'b0, irq_en = 1'b0, flag_clr = 1'b0, power_down = 1'b0;
  logic [CNT_W-1:0] reload_data = '0;
  logic evt_flag, irq, wake;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [PRE_W-1:0] m_pre;
  logic [CNT_W-1:0] m_cnt, m_rel;
  logic m_flag, m_irq, m_wake;

  always #(CLK_PER/2) clk = ~clk;

  wake_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_wake_timer (
    .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .src_sel(src_sel),
    .run_en(run_en), .reload_we(reload_we), .reload_data(reload_data),
    .irq_en(irq_en), .flag_clr(flag_clr), .power_down(power_down),
    .evt_flag(evt_flag), .irq(irq), .wake(wake)
  );

  function automatic logic next_flag(logic ev, logic cl, logic f);
    return ev ? 1'b1 : (cl ? 1'b0 : f);
  endfunction

  always @(posedge clk) begin
    logic step, ev, fn;
    if (rst) begin
      m_pre = PMAX; m_cnt = '1; m_rel = '1;
      m_flag = 0; m_irq = 0; m_wake = 0;
    end else begin
      step = run_en && (src_sel ? tick_b : tick_a);
      ev   = step && m_pre == '0 && m_cnt == '0;
      if (reload_we && !run_en) begin
        m_cnt = reload_data; m_pre = PMAX;
      end else if (ev) begin
        m_cnt = m_rel; m_pre = PMAX;
      end else if (step) begin
        if (m_pre == '0) begin m_pre = PMAX; m_cnt = m_cnt - 1'b1; end
        else m_pre = m_pre - 1'b1;
      end
      if (reload_we) m_rel = reload_data;
      fn     = next_flag(ev, flag_clr, m_flag);
      m_flag = fn;
      m_irq  = fn & irq_en;
      m_wake = fn & (irq_en | power_down);
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 flag", evt_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 wake", wake, 1'b0);

    // R5 load while idle, R2 period (3+1)*8 = 32
    reload_we = 1; reload_data = 6'd3; cyc(1);
    reload_we = 0; run_en = 1;
    cyc(31); chk("R2 before period", evt_flag, 1'b0);
    cyc(1);  chk("R2/R3 at period", evt_flag, 1'b1);
    chk("R8 irq off while irq_en=0", irq, 1'b0);
    chk("R9 wake off", wake, 1'b0);
    power_down = 1;
    cyc(1); chk("R9 wake in power-down", wake, 1'b1);
    flag_clr = 1;
    cyc(1); chk("R7 cleared", evt_flag, 1'b0);
    flag_clr = 0; reload_we = 1; reload_data = 6'd0;   // write while running
    cyc(1); reload_we = 0;
    cyc(28); chk("R5 old reload still counting", evt_flag, 1'b0);
    cyc(1);  chk("R3 reload event under power-down", evt_flag, 1'b1);
    chk("R9 wake from power-down event", wake, 1'b1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    cyc(6); chk("R5 new reload pending", evt_flag, 1'b0);
    cyc(1); chk("R5 new reload period 8", evt_flag, 1'b1);
    power_down = 0;

    // R7 clear and event in the same cycle
    flag_clr = 1;
    cyc(7); chk("R7 clear holding", evt_flag, 1'b0);
    cyc(1); chk("R7 event beats clear", evt_flag, 1'b1);
    cyc(1); chk("R7 clear after event", evt_flag, 1'b0);
    flag_clr = 0; irq_en = 1;
    cyc(7); chk("R8 irq at event", irq, 1'b1);
    chk("R9 wake with irq_en", wake, 1'b1);
    flag_clr = 1; cyc(1); flag_clr = 0;

    // R4 disabled holds
    run_en = 0;
    cyc(40); chk("R4 no event while disabled", evt_flag, 1'b0);
    reload_we = 1; reload_data = 6'd1; cyc(1);
    reload_we = 0; run_en = 1;
    cyc(15); chk("R5 idle load before 16", evt_flag, 1'b0);
    cyc(1);  chk("R5 idle load period 16", evt_flag, 1'b1);
    flag_clr = 1; cyc(1); flag_clr = 0;

    // R6 source select
    run_en = 0; reload_we = 1; reload_data = 6'd0; cyc(1);
    reload_we = 0; src_sel = 1; tick_b = 0; tick_a = 1; run_en = 1;
    cyc(40); chk("R6 unselected tick ignored", evt_flag, 1'b0);
    tick_b = 1;
    cyc(7); chk("R6 tick_b counting", evt_flag, 1'b0);
    cyc(1); chk("R6 tick_b event", evt_flag, 1'b1);

    // random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      tick_a      = ($urandom % 4) != 0;
      tick_b      = ($urandom % 2) != 0;
      if ($urandom % 64 == 0) src_sel = ~src_sel;
      run_en      = ($urandom % 16) != 0;
      reload_we   = ($urandom % 40) == 0;
      reload_data = CNT_W'($urandom % 4);
      flag_clr    = ($urandom % 10) == 0;
      irq_en      = ($urandom % 3) != 0;
      power_down  = ($urandom % 4) == 0;
      cyc(1);
      chk("R3 random flag", evt_flag, m_flag);
      chk("R8 random irq", irq, m_irq);
      chk("R9 random wake", wake, m_wake);
    end
    summary();
  end
endmodule